// File: doc/BRIEF.md
# Mute-Control Pin Controller

This block produces the level and the output enable for an external mute-control pin that sits beside a multichannel DAC. The pin is asserted for three reasons: software sets a mute request bit, every DAC channel has carried a long run of all-zero samples, or the serial port reports a clock fault. The block takes the per-channel sample words with a sample strobe, a power-down bit, the mute request, the clock-fault flag and a polarity-invert bit. It drives a registered pin level and a registered enable, so that the pad cell outside can float the pin.

Each channel has its own run-length counter. The counter advances on every strobed all-zero sample and restarts on any nonzero sample. A channel counts as silent once its counter reaches the run limit. The zero-data mute needs every channel to be silent at the same time. A single nonzero sample on any channel releases it at once. The clock-fault flag is stretched by a hold counter for a set number of sample strobes after the flag drops, so the pin does not chatter.

The pin floats for a fixed settling window after reset and for as long as the power-down bit is set.

Top module: `mute_pin_ctrl`

## Requirements
- R1: After reset is released, `mute_oe_o` stays low until `PWRUP_CYC` clock cycles have passed. It then goes high if power-down is clear.
- R2: While `pwr_down` is 1, `mute_oe_o` is 0 from the next clock edge. When `pwr_down` returns to 0 after the settling window, `mute_oe_o` is 1 again on the next edge.
- R3: `user_mute` = 1 asserts the pin on the next clock edge.
- R4: A channel counts as silent after `ZERO_RUN` strobed samples in a row that are all zero. Cycles with `sample_valid` low are not counted. When every channel is silent, the pin asserts on the edge after the strobe that completed the last run. After only `ZERO_RUN`-1 such samples, it stays deasserted.
- R5: A strobed nonzero sample on any channel clears the zero-data mute on the following edge and restarts that channel's run from zero.
- R6: If at least one channel keeps carrying nonzero data, and there is no user mute and no clock fault, the pin stays deasserted.
- R7: `clk_err` = 1 asserts the pin on the next clock edge.
- R8: After `clk_err` falls, the pin stays asserted through `ERR_HOLD`-1 sample strobes. It deasserts on the edge after the `ERR_HOLD`-th strobe, provided no other mute cause is active.
- R9: With `invert_pol` = 0, an asserted pin level is 1. With `invert_pol` = 1, every pin level is inverted, so asserted is 0 and idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: `chan_data` holds one sample per channel |
| chan_data | input | NCH*DW | Channel samples, channel k at bits [k*DW +: DW] |
| pwr_down | input | 1 | Power-down bit; floats the pin |
| user_mute | input | 1 | Software mute request |
| clk_err | input | 1 | Serial-port clock fault flag |
| invert_pol | input | 1 | Inverts the pin polarity |
| mute_pin_o | output | 1 | Registered pin level |
| mute_oe_o | output | 1 | Registered output enable for the pad |

## Verification
The bench targets the run boundaries, with one strobe short of the limit and then the exact limit. A counter that is off by one would mute one sample early or one sample late. For each channel in turn, that channel alone carries nonzero data. A design that ORs the silence flags would then mute when it should not. The bench interleaves idle cycles carrying zeros, which catches a counter that counts clocks rather than strobes. It also places the clock-fault release exactly at `ERR_HOLD`-1 and `ERR_HOLD` strobes, which exposes a hold that is too short or that never ends. Polarity inversion and the float windows are checked in both the idle and the asserted state.

// File: rtl/mute_pin_pkg.sv
package mute_pin_pkg;

  // Run-length step: restart on a nonzero sample, saturate at the limit.
  function automatic int unsigned run_step(input int unsigned cnt,
                                           input logic zero,
                                           input int unsigned lim);
    if (!zero)           return 0;
    else if (cnt >= lim) return lim;
    else                 return cnt + 1;
  endfunction

  // Hold-down step: reload while the fault is present, else count down per strobe.
  function automatic int unsigned hold_step(input int unsigned cnt,
                                            input logic fault,
                                            input logic strobe,
                                            input int unsigned lim);
    if (fault)                  return lim;
    else if (strobe && cnt != 0) return cnt - 1;
    else                        return cnt;
  endfunction

  // Pin level from the assertion request and the polarity bit.
  function automatic logic pin_level(input logic want, input logic inv);
    return want ^ inv;
  endfunction

endpackage

// File: rtl/mute_zero_det.sv
module mute_zero_det #(
  parameter int DW       = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample,
  output logic          silent
);
  import mute_pin_pkg::*;
  localparam int CW = $clog2(ZERO_RUN + 1);

  logic [CW-1:0] run_q;
  logic          is_zero;

  assign is_zero = (sample == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (sample_valid) run_q <= CW'(run_step(32'(run_q), is_zero, ZERO_RUN));
  end

  assign silent = (32'(run_q) == ZERO_RUN);
endmodule

// File: rtl/mute_err_hold.sv
module mute_err_hold #(
  parameter int ERR_HOLD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_valid,
  input  logic clk_err,
  output logic err_active
);
  import mute_pin_pkg::*;
  localparam int HW = $clog2(ERR_HOLD + 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= HW'(hold_step(32'(hold_q), clk_err, sample_valid, ERR_HOLD));
  end

  assign err_active = clk_err | (hold_q != '0);
endmodule

// File: rtl/mute_pwrup.sv
module mute_pwrup #(
  parameter int PWRUP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int PW = $clog2(PWRUP_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (32'(cnt_q) < PWRUP_CYC) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (32'(cnt_q) == PWRUP_CYC);
endmodule

// File: rtl/mute_pin_ctrl.sv
module mute_pin_ctrl #(
  parameter int NCH       = 6,
  parameter int DW        = 24,
  parameter int ZERO_RUN  = 8192,
  parameter int ERR_HOLD  = 1024,
  parameter int PWRUP_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [NCH*DW-1:0] chan_data,
  input  logic              pwr_down,
  input  logic              user_mute,
  input  logic              clk_err,
  input  logic              invert_pol,
  output logic              mute_pin_o,
  output logic              mute_oe_o
);
  import mute_pin_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] ch_silent;
  logic           all_zero;
  logic           err_active;
  logic           pwrup_done;
  logic           mute_req;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    mute_zero_det #(.DW(DW), .ZERO_RUN(ZERO_RUN)) u_zd (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_valid (sample_valid),
      .sample       (chan_data[k*DW +: DW]),
      .silent       (ch_silent[k])
    );
  end

  assign all_zero = &ch_silent;

  mute_err_hold #(.ERR_HOLD(ERR_HOLD)) u_eh (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .clk_err      (clk_err),
    .err_active   (err_active)
  );

  mute_pwrup #(.PWRUP_CYC(PWRUP_CYC)) u_pu (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (pwrup_done)
  );

  assign mute_req = user_mute | all_zero | err_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_pin_o <= 1'b0;
      mute_oe_o  <= 1'b0;
    end else begin
      mute_pin_o <= pin_level(mute_req, invert_pol);
      mute_oe_o  <= pwrup_done & ~pwr_down;
    end
  end
endmodule

// File: rtl/mute_pin_ctrl_chk.sv
module mute_pin_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_valid,
  input logic data_nonzero,
  input logic pwr_down,
  input logic user_mute,
  input logic clk_err,
  input logic invert_pol,
  input logic mute_pin_o,
  input logic mute_oe_o,
  input logic all_zero,
  input logic err_active,
  input logic pwrup_done
);
  AST_SETTLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_done |=> !mute_oe_o);                                              // R1
  AST_PDN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !mute_oe_o);                                                 // R2
  AST_USER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    user_mute |=> (mute_pin_o != $past(invert_pol)));                         // R3
  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && data_nonzero) |=> !all_zero);                            // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mute && !all_zero && !err_active) |=> (mute_pin_o == $past(invert_pol))); // R6
  AST_CLKERR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |=> (mute_pin_o != $past(invert_pol)));                           // R7
  AST_ERR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_err) |-> err_active);                                           // R8
endmodule

bind mute_pin_ctrl mute_pin_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .data_nonzero (|chan_data),
  .pwr_down     (pwr_down),
  .user_mute    (user_mute),
  .clk_err      (clk_err),
  .invert_pol   (invert_pol),
  .mute_pin_o   (mute_pin_o),
  .mute_oe_o    (mute_oe_o),
  .all_zero     (all_zero),
  .err_active   (err_active),
  .pwrup_done   (pwrup_done)
);

// File: tb/mute_pin_ctrl_tb.sv
module mute_pin_ctrl_tb;
  localparam int NCH = 3, DW = 8, ZR = 16, EH = 8, PU = 10;

  logic clk = 0, rst_n = 0, sample_valid = 0;
  logic [NCH*DW-1:0] chan_data = '1;
  logic pwr_down = 0, user_mute = 0, clk_err = 0, invert_pol = 0;
  logic mute_pin_o, mute_oe_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mute_pin_ctrl #(.NCH(NCH), .DW(DW), .ZERO_RUN(ZR), .ERR_HOLD(EH), .PWRUP_CYC(PU)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .chan_data(chan_data),
    .pwr_down(pwr_down), .user_mute(user_mute), .clk_err(clk_err),
    .invert_pol(invert_pol), .mute_pin_o(mute_pin_o), .mute_oe_o(mute_oe_o));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // expected pin level: request XOR polarity
  function automatic logic want(input logic req);
    return req ^ invert_pol;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe(input logic [NCH*DW-1:0] d);
    chan_data = d; sample_valid = 1;
    step();
    sample_valid = 0; chan_data = '1;
  endtask

  function automatic logic [NCH*DW-1:0] one_live(input int k);
    logic [NCH*DW-1:0] d = '0;
    d[k*DW] = 1'b1;
    return d;
  endfunction

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step(); step();
    chk(mute_oe_o, 1'b0, "R1 oe low in settling window");
    repeat (PU + 2) step();
    chk(mute_oe_o, 1'b1, "R1 oe high after settling");
    chk(mute_pin_o, want(0), "R6 idle after reset");

    user_mute = 1; step();
    chk(mute_pin_o, 1'b1, "R3 user mute asserts");
    invert_pol = 1; step();
    chk(mute_pin_o, 1'b0, "R9 inverted asserted level");
    user_mute = 0; step();
    chk(mute_pin_o, 1'b1, "R9 inverted idle level");
    invert_pol = 0; step();
    chk(mute_pin_o, 1'b0, "R3 release user mute");

    // R4: ZR-1 zero strobes with idle zero cycles between them
    for (int i = 0; i < ZR - 1; i++) begin
      strobe('0);
      chan_data = '0; step(); chan_data = '1;
    end
    step();
    chk(mute_pin_o, 1'b0, "R4 one strobe short of limit");
    strobe('0); step();
    chk(mute_pin_o, 1'b1, "R4 all channels silent");
    invert_pol = 1; step();
    chk(mute_pin_o, 1'b0, "R9 inverted zero mute");
    invert_pol = 0; step();

    // R5: one nonzero sample on channel 1 clears and restarts
    strobe(one_live(1)); step();
    chk(mute_pin_o, 1'b0, "R5 nonzero clears zero mute");
    for (int i = 0; i < ZR - 1; i++) strobe('0);
    step();
    chk(mute_pin_o, 1'b0, "R5 run restarted from zero");
    strobe('0); step();
    chk(mute_pin_o, 1'b1, "R5 full run re-mutes");

    // R6: each channel alone stays live
    for (int k = 0; k < NCH; k++) begin
      strobe('1);
      for (int i = 0; i < ZR + 3; i++) begin
        strobe(one_live(k));
        chk(mute_pin_o, 1'b0, "R6 one live channel no mute");
      end
    end

    // R7 / R8: clock fault and hold-down
    step();
    clk_err = 1; step();
    chk(mute_pin_o, 1'b1, "R7 clock error asserts");
    clk_err = 0;
    for (int i = 0; i < EH - 1; i++) begin
      strobe('1); step();
      chk(mute_pin_o, 1'b1, "R8 held during hold window");
    end
    strobe('1); step();
    chk(mute_pin_o, 1'b0, "R8 released after hold window");

    // R2: power-down floats the pin, then restores
    pwr_down = 1; step();
    chk(mute_oe_o, 1'b0, "R2 power-down floats pin");
    user_mute = 1; step();
    chk(mute_oe_o, 1'b0, "R2 float overrides mute");
    pwr_down = 0; user_mute = 0; step();
    chk(mute_oe_o, 1'b1, "R2 driven after power-down");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule